// File: doc/BRIEF.md
# Gesture Signature Extractor and Matcher

This block turns a recorded marker path into a tempo code. A producer writes up to `2**AW` X/Y coordinate pairs into an internal point store through a simple write port. It then gives the point count and a one-cycle `start` pulse. The block reads the store twice:

- The first read finds the extent of each axis.
- The second read labels every point as above or not above that axis midpoint. It keeps an X/Y bit pair only where either label changes.

The resulting short signature no longer depends on how large the gesture was drawn or how many frames it spanned. It is compared exactly against a fixed table of templates.

When the comparison finishes, `done` pulses for one cycle. `tempo_out` then shows the code of the first matching template. If no template matches, `tempo_out` shows the value presented on `cur_tempo`, so the music keeps its present tempo. `matched` tells the two cases apart. Both outputs hold until the next result.

Top module: `gesture_sig_matcher`

## Requirements
- R1: A write (`wr_en` high) stores `wr_x`/`wr_y` at `wr_addr` only while `busy` is low; writes made while `busy` is high leave the stored points unchanged.
- R2: A `start` pulse while `busy` is low raises `busy` on the next cycle and begins processing `num_pts` points; a `start` pulse while `busy` is high is ignored and produces no extra result.
- R3: Each axis midpoint is floor((min+max)/2) over the processed points; a point's bit on that axis is 1 only when its coordinate is strictly greater than the midpoint, so a coordinate equal to the midpoint yields 0.
- R4: The first point always opens signature entry 0; a further entry is appended only when the X bit or the Y bit differs from the previous point's, so repeated points (a slower gesture) give the same signature; entry i holds the X bit and Y bit of the point that opened it.
- R5: A gesture drawn at a different scale but with the same shape gives the same result.
- R6: The template table, listed as (X,Y) entry pairs in entry order with their codes, is: T0 (0,0)(1,1) code 2; T1 (0,1)(1,0)(0,1) code 3; T2 (0,0)(1,0)(1,1)(0,1) code 4; T3 (0,1)(1,1)(1,0)(0,0) code 5; T4 same as T2, code 7.
- R7: A template matches only when its length equals the signature length and every X and Y entry is equal; when several match, the lowest-numbered template wins and `matched` is 1.
- R8: With no matching template, or when the signature would need more than 16 entries, `tempo_out` takes the value of `cur_tempo` one cycle before `done` and `matched` is 0.
- R9: `done` is high for exactly one cycle per accepted start, in the same cycle `busy` falls; `tempo_out` and `matched` change only then and hold afterwards.
- R10: A count of 0 or 1 points gives a signature that matches no template; a count above `2**AW` is clamped to `2**AW`.
- R11: After reset `busy`, `done`, `matched` are 0 and `tempo_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Point write strobe |
| wr_addr | input | AW | Point index to write |
| wr_x | input | CW | X coordinate |
| wr_y | input | CW | Y coordinate |
| num_pts | input | AW+1 | Number of stored points to process |
| start | input | 1 | Begin processing (one cycle) |
| cur_tempo | input | TW | Tempo code in use, returned when nothing matches |
| busy | output | 1 | Processing in progress |
| done | output | 1 | One-cycle result strobe |
| tempo_out | output | TW | Resulting tempo code |
| matched | output | 1 | Result came from a template |

## Verification
Most internal faults only show up at the ports when `done` pulses, roughly 2·N+4 cycles after `start`. A wrong extent or midpoint, a bit taken with the wrong comparison, or a lost or extra signature entry each turns an expected template code into the `cur_tempo` fallback, or into a different code. The point sets are chosen so that each fault produces a distinct outcome. An equal-to-midpoint point, odd min+max sums, repeated points, a scaled copy and a 20-entry signature aim at the individual steps. A faulty busy or start guard shows as an extra `done` or a changed later result. A corrupted write guard shows when a second run is made on the same buffer.

// File: rtl/gsm_pkg.sv
package gsm_pkg;

  localparam int MAX_SEQ = 16;
  localparam int LW      = $clog2(MAX_SEQ + 1);
  localparam int NUM_TPL = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_PASS1, ST_PASS2, ST_FIN} gsm_state_e;

  // Template entry i sits at bit i of the X and Y vectors.
  function automatic logic [LW-1:0] tpl_len(input int i);
    case (i)
      0:       return LW'(2);
      1:       return LW'(3);
      default: return LW'(4);
    endcase
  endfunction

  function automatic logic [MAX_SEQ-1:0] tpl_x(input int i);
    case (i)
      0, 1:    return MAX_SEQ'(16'h0002);
      default: return MAX_SEQ'(16'h0006);
    endcase
  endfunction

  function automatic logic [MAX_SEQ-1:0] tpl_y(input int i);
    case (i)
      0:       return MAX_SEQ'(16'h0002);
      1:       return MAX_SEQ'(16'h0005);
      3:       return MAX_SEQ'(16'h0003);
      default: return MAX_SEQ'(16'h000C);
    endcase
  endfunction

  function automatic int tpl_code(input int i);
    case (i)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      3:       return 5;
      default: return 7;
    endcase
  endfunction

endpackage

// File: rtl/gsm_point_buf.sv
module gsm_point_buf #(
  parameter int AW = 6,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wx,
  input  logic [CW-1:0] wy,
  input  logic [AW-1:0] raddr,
  output logic [CW-1:0] rx,
  output logic [CW-1:0] ry
);
  localparam int DEPTH = 1 << AW;

  logic [2*CW-1:0] mem [DEPTH];
  logic [2*CW-1:0] rdata;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wx, wy};
    rdata <= mem[raddr];
  end

  assign rx = rdata[2*CW-1:CW];
  assign ry = rdata[CW-1:0];
endmodule

// File: rtl/gsm_extent.sv
module gsm_extent #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          vld,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  output logic [CW-1:0] mid_x,
  output logic [CW-1:0] mid_y
);
  logic [CW-1:0] lo_x, hi_x, lo_y, hi_y;
  logic [CW:0]   sum_x, sum_y;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lo_x <= '1;
      lo_y <= '1;
      hi_x <= '0;
      hi_y <= '0;
    end else if (vld) begin
      if (x < lo_x) lo_x <= x;
      if (x > hi_x) hi_x <= x;
      if (y < lo_y) lo_y <= y;
      if (y > hi_y) hi_y <= y;
    end
  end

  assign sum_x = {1'b0, lo_x} + {1'b0, hi_x};
  assign sum_y = {1'b0, lo_y} + {1'b0, hi_y};
  assign mid_x = sum_x[CW:1];
  assign mid_y = sum_y[CW:1];
endmodule

// File: rtl/gsm_seq_builder.sv
module gsm_seq_builder
  import gsm_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               vld,
  input  logic [CW-1:0]      x,
  input  logic [CW-1:0]      y,
  input  logic [CW-1:0]      mid_x,
  input  logic [CW-1:0]      mid_y,
  output logic [MAX_SEQ-1:0] sig_x,
  output logic [MAX_SEQ-1:0] sig_y,
  output logic [LW-1:0]      sig_len,
  output logic               ovf
);
  logic first, prev_bx, prev_by;
  logic bx, by, edge_seen;

  assign bx        = (x > mid_x);
  assign by        = (y > mid_y);
  assign edge_seen = first || (bx != prev_bx) || (by != prev_by);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      first   <= 1'b1;
      prev_bx <= 1'b0;
      prev_by <= 1'b0;
      sig_x   <= '0;
      sig_y   <= '0;
      sig_len <= '0;
      ovf     <= 1'b0;
    end else if (vld) begin
      first   <= 1'b0;
      prev_bx <= bx;
      prev_by <= by;
      if (edge_seen) begin
        if (sig_len == LW'(MAX_SEQ)) begin
          ovf <= 1'b1;
        end else begin
          for (int i = 0; i < MAX_SEQ; i++) begin
            if (sig_len == LW'(i)) begin
              sig_x[i] <= bx;
              sig_y[i] <= by;
            end
          end
          sig_len <= sig_len + LW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/gsm_matcher.sv
module gsm_matcher
  import gsm_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic [MAX_SEQ-1:0] sig_x,
  input  logic [MAX_SEQ-1:0] sig_y,
  input  logic [LW-1:0]      sig_len,
  input  logic               ovf,
  output logic               hit,
  output logic [TW-1:0]      code
);
  logic [MAX_SEQ-1:0] mask;
  logic [NUM_TPL-1:0] tpl_hit;

  always_comb begin
    for (int b = 0; b < MAX_SEQ; b++) mask[b] = (LW'(b) < sig_len);
  end

  for (genvar t = 0; t < NUM_TPL; t++) begin : g_tpl
    assign tpl_hit[t] = !ovf && (sig_len == tpl_len(t)) &&
                        (((sig_x ^ tpl_x(t)) & mask) == '0) &&
                        (((sig_y ^ tpl_y(t)) & mask) == '0);
  end

  always_comb begin
    hit  = 1'b0;
    code = '0;
    for (int t = NUM_TPL - 1; t >= 0; t--) begin
      if (tpl_hit[t]) begin
        hit  = 1'b1;
        code = TW'(tpl_code(t));
      end
    end
  end
endmodule

// File: rtl/gesture_sig_matcher.sv
module gesture_sig_matcher
  import gsm_pkg::*;
#(
  parameter int CW = 10,
  parameter int AW = 6,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_x,
  input  logic [CW-1:0] wr_y,
  input  logic [AW:0]   num_pts,
  input  logic          start,
  input  logic [TW-1:0] cur_tempo,
  output logic          busy,
  output logic          done,
  output logic [TW-1:0] tempo_out,
  output logic          matched
);
  localparam int CNTW = AW + 1;
  localparam logic [CNTW-1:0] DEPTH = CNTW'(1 << AW);

  gsm_state_e state;
  logic [CNTW-1:0] n_q, idx;
  logic rd_vld, issue, pass_end, in_pass, accept;
  logic [CW-1:0] rx, ry, mid_x, mid_y;
  logic [MAX_SEQ-1:0] sig_x, sig_y;
  logic [LW-1:0] sig_len;
  logic ovf, hit;
  logic [TW-1:0] code;

  assign in_pass  = (state == ST_PASS1) || (state == ST_PASS2);
  assign issue    = in_pass && (idx < n_q);
  assign pass_end = in_pass && (idx == n_q) && !rd_vld;
  assign accept   = (state == ST_IDLE) && start;

  gsm_point_buf #(.AW(AW), .CW(CW)) u_buf (
    .clk  (clk),
    .we   (wr_en && (state == ST_IDLE)),
    .waddr(wr_addr),
    .wx   (wr_x),
    .wy   (wr_y),
    .raddr(idx[AW-1:0]),
    .rx   (rx),
    .ry   (ry)
  );

  gsm_extent #(.CW(CW)) u_ext (
    .clk  (clk),
    .rst  (rst),
    .clr  (accept),
    .vld  (rd_vld && (state == ST_PASS1)),
    .x    (rx),
    .y    (ry),
    .mid_x(mid_x),
    .mid_y(mid_y)
  );

  gsm_seq_builder #(.CW(CW)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .clr    (accept),
    .vld    (rd_vld && (state == ST_PASS2)),
    .x      (rx),
    .y      (ry),
    .mid_x  (mid_x),
    .mid_y  (mid_y),
    .sig_x  (sig_x),
    .sig_y  (sig_y),
    .sig_len(sig_len),
    .ovf    (ovf)
  );

  gsm_matcher #(.TW(TW)) u_match (
    .sig_x  (sig_x),
    .sig_y  (sig_y),
    .sig_len(sig_len),
    .ovf    (ovf),
    .hit    (hit),
    .code   (code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      n_q       <= '0;
      idx       <= '0;
      rd_vld    <= 1'b0;
      done      <= 1'b0;
      tempo_out <= '0;
      matched   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            n_q    <= (num_pts > DEPTH) ? DEPTH : num_pts;
            idx    <= '0;
            rd_vld <= 1'b0;
            state  <= ST_PASS1;
          end
        end
        ST_PASS1, ST_PASS2: begin
          rd_vld <= issue;
          if (issue) idx <= idx + CNTW'(1);
          if (pass_end) begin
            idx   <= '0;
            state <= (state == ST_PASS1) ? ST_PASS2 : ST_FIN;
          end
        end
        default: begin
          tempo_out <= hit ? code : cur_tempo;
          matched   <= hit;
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/gsm_checker.sv
module gsm_checker #(
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          matched,
  input logic [TW-1:0] tempo_out,
  input logic [TW-1:0] cur_tempo
);
  // R2: an accepted start raises busy
  a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  // R9: busy only ends together with the result strobe
  a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R9: done lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: a result follows a busy period
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  // R9: the tempo output moves only with done
  a_r9_out_only_on_done: assert property (@(posedge clk) disable iff (rst)
    (tempo_out != $past(tempo_out)) |-> done);

  // R8: an unmatched result returns the tempo in use
  a_r8_fallback: assert property (@(posedge clk) disable iff (rst)
    (done && !matched) |-> (tempo_out == $past(cur_tempo)));
endmodule

bind gesture_sig_matcher gsm_checker #(.TW(TW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .matched  (matched),
  .tempo_out(tempo_out),
  .cur_tempo(cur_tempo)
);

// File: tb/gesture_sig_matcher_tb.sv
module gesture_sig_matcher_tb;
  localparam int CW = 10;
  localparam int AW = 6;
  localparam int TW = 4;

  logic clk = 0, rst = 1;
  logic wr_en = 0, start = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_x = '0, wr_y = '0;
  logic [AW:0]   num_pts = '0;
  logic [TW-1:0] cur_tempo = '0;
  logic busy, done, matched;
  logic [TW-1:0] tempo_out;

  gesture_sig_matcher #(.CW(CW), .AW(AW), .TW(TW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_x(wr_x),
    .wr_y(wr_y), .num_pts(num_pts), .start(start), .cur_tempo(cur_tempo),
    .busy(busy), .done(done), .tempo_out(tempo_out), .matched(matched)
  );

  always #5 clk = ~clk;

  typedef struct { int t; int m; string tag; } exp_t;
  exp_t sb[$];
  exp_t e;
  int errors = 0, checks = 0, cyc = 0;
  int px[64], py[64];

  // R6 template table copy: lengths, X/Y bit vectors (entry i at bit i), codes
  int tl[5] = '{2, 3, 4, 4, 4};
  int tx[5] = '{2, 2, 6, 6, 6};
  int ty[5] = '{2, 5, 12, 3, 12};
  int tc[5] = '{2, 3, 4, 5, 7};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic void model(input int n, input int cur, output int et, output int em);
    int nx = (n > 64) ? 64 : n;
    int lox = 1 << 30, hix = -1, loy = 1 << 30, hiy = -1;
    int mx, my, len = 0, pbx = 0, pby = 0;
    bit ovf = 0;
    int sx[16], sy[16];
    for (int i = 0; i < nx; i++) begin
      if (px[i] < lox) lox = px[i];
      if (px[i] > hix) hix = px[i];
      if (py[i] < loy) loy = py[i];
      if (py[i] > hiy) hiy = py[i];
    end
    mx = (lox + hix) / 2;
    my = (loy + hiy) / 2;
    for (int i = 0; i < nx; i++) begin
      int bx = (px[i] > mx) ? 1 : 0;
      int by = (py[i] > my) ? 1 : 0;
      if (i == 0 || bx != pbx || by != pby) begin
        if (len == 16) ovf = 1;
        else begin sx[len] = bx; sy[len] = by; len++; end
      end
      pbx = bx; pby = by;
    end
    et = cur; em = 0;
    for (int t = 4; t >= 0; t--) begin
      bit same = !ovf && (len == tl[t]);
      for (int k = 0; k < len && k < 16; k++)
        if (sx[k] != ((tx[t] >> k) & 1) || sy[k] != ((ty[t] >> k) & 1)) same = 0;
      if (same) begin et = tc[t]; em = 1; end
    end
  endfunction

  task automatic run_case(input int n, input int cur, input string tag,
                          input bit do_wr, input bit disturb);
    int et, em;
    model(n, cur, et, em);
    sb.push_back('{et, em, tag});
    if (do_wr) begin
      for (int i = 0; i < n && i < 64; i++) begin
        @(posedge clk); #1;
        wr_en = 1; wr_addr = AW'(i); wr_x = CW'(px[i]); wr_y = CW'(py[i]);
      end
    end
    @(posedge clk); #1;
    wr_en = 0; cur_tempo = TW'(cur); num_pts = (AW+1)'(n); start = 1;
    @(posedge clk); #1;
    start = 0;
    chk(busy == 1'b1, {"R2 busy after start ", tag}, busy, 1);
    if (disturb) begin
      @(posedge clk); #1;
      start = 1; num_pts = 7'd1; wr_en = 1; wr_addr = '0; wr_x = '1; wr_y = '1;
      @(posedge clk); #1;
      start = 0; wr_en = 0;
    end
    while (busy) begin @(posedge clk); #1; end
    repeat (3) @(posedge clk);
    #1;
    chk(tempo_out == TW'(et), {"R9 hold ", tag}, tempo_out, et);
  endtask

  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) chk(0, "R2 unexpected done", 1, 0);
      else begin
        e = sb.pop_front();
        chk(tempo_out == TW'(e.t), {"tempo ", e.tag}, tempo_out, e.t);
        chk(matched == e.m[0], {"matched ", e.tag}, matched, e.m);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      chk(0, "watchdog", cyc, 0);
      summary();
    end
  end

  task automatic sp(input int i, input int x, input int y);
    px[i] = x; py[i] = y;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(busy == 0, "R11 busy", busy, 0);
    chk(done == 0, "R11 done", done, 0);
    chk(matched == 0, "R11 matched", matched, 0);
    chk(tempo_out == 0, "R11 tempo", tempo_out, 0);

    // R7 T0 diagonal, large
    sp(0,10,10); sp(1,20,20); sp(2,100,100); sp(3,110,110);
    run_case(4, 9, "R7 diag", 1, 0);
    // R5 same shape, small scale
    sp(0,1,1); sp(1,2,2); sp(2,5,5); sp(3,6,6);
    run_case(4, 9, "R5 scaled", 1, 0);
    // R6 T1
    sp(0,0,100); sp(1,100,0); sp(2,0,100);
    run_case(3, 1, "R6 zigzag", 1, 0);
    // R7 square: T2 wins over identical T4
    sp(0,0,0); sp(1,100,0); sp(2,100,100); sp(3,0,100);
    run_case(4, 1, "R7 priority", 1, 0);
    // R4 each corner repeated three times
    for (int i = 0; i < 12; i++) begin
      int c = i / 3;
      sp(i, (c == 1 || c == 2) ? 100 : 0, (c >= 2) ? 100 : 0);
    end
    run_case(12, 1, "R4 slow", 1, 0);
    // R6 T3
    sp(0,0,100); sp(1,100,100); sp(2,100,0); sp(3,0,0);
    run_case(4, 1, "R6 T3", 1, 0);
    // R8 unknown shape
    sp(0,0,0); sp(1,100,100); sp(2,0,0);
    run_case(3, 6, "R8 unknown", 1, 0);
    // R8 20 entries exceed 16
    for (int i = 0; i < 20; i++) sp(i, (i % 2) ? 100 : 0, 0);
    run_case(20, 11, "R8 overflow", 1, 0);
    // R3 equal-to-midpoint and floor
    sp(0,0,0); sp(1,5,2); sp(2,11,11);
    run_case(3, 1, "R3 midpoint", 1, 0);
    // R10 zero and one point
    run_case(0, 3, "R10 zero", 0, 0);
    sp(0,50,50);
    run_case(1, 8, "R10 one", 1, 0);
    // R10 clamp: count 100 processes 64 copies of one corner pair
    for (int i = 0; i < 64; i++) sp(i, (i < 32) ? 0 : 100, (i < 32) ? 0 : 100);
    run_case(100, 1, "R10 clamp", 1, 0);
    // R1 R2 start and writes during busy ignored, then rerun unchanged buffer
    sp(0,0,100); sp(1,100,100); sp(2,100,0); sp(3,0,0);
    run_case(4, 1, "R2 busy start", 1, 1);
    run_case(4, 1, "R1 busy write", 0, 0);

    repeat (20) @(posedge clk);
    #1;
    chk(sb.size() == 0, "R9 results outstanding", sb.size(), 0);
    summary();
  end
endmodule